// File: doc/BRIEF.md
# Cartridge Bank Controller with Time-of-Day Registers

This block sits between a CPU with a 16-bit address bus and 8-bit data bus and the storage on a plug-in cartridge. The CPU cannot write to the ROM, so its stores into the lower half of the address space (0x0000–0x7FFF) are read as commands. These commands pick which 16 KiB ROM bank appears in the upper ROM window, which 8 KiB external RAM bank appears in the 0xA000–0xBFFF window, whether that RAM can be reached at all, and whether a time-of-day register takes the place of the RAM in that window.

The block keeps a running time (seconds, minutes, hours and a 9-bit day count) that advances on a one-cycle `tick` strobe. Software cannot read this running time directly. A latch command copies it into five readable snapshot registers, and the CPU then reads or writes these registers through the RAM window. The ROM and RAM arrays sit outside the block. It drives their addresses and the RAM write strobe, and it steers their read data back to the CPU.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write to 0x0000–0x1FFF with data 0x0A enables external RAM. Data 0x00 disables it. Any other data leaves the enable unchanged.
- R2: A write to 0x2000–0x3FFF requests ROM bank data[6:0], and a request of 0 becomes bank 1. For addresses 0x4000–0x7FFF, `rom_addr` = bank × 16384 + addr[13:0]. For 0x0000–0x3FFF, `rom_addr` = addr[13:0].
- R3: A ROM bank request of ROM_BANKS or more is ignored, and the previously selected bank stays selected.
- R4: A write to 0x4000–0x5FFF with data 0–3 selects that RAM bank and unmaps the time registers. Data 0x08–0x0C maps time register (data − 8) into the window. Every other value changes nothing.
- R5: A read of 0xA000–0xBFFF returns the selected time register when one is mapped. Otherwise, with RAM enabled, it returns RAM data at `ram_addr` = bank × 8192 + addr[12:0]. In every other case it returns 0xFF. Reads above 0xBFFF return 0xFF.
- R6: A write to the window updates the selected snapshot register and the matching field of the running time when a time register is mapped. It pulses `ram_we` only when RAM is enabled and no time register is mapped. Otherwise it is dropped.
- R7: A write of 1 to 0x6000–0x7FFF while not latched takes a snapshot and sets the latched state. Further writes of 1 do nothing until a write of 0 clears the latched state.
- R8: Snapshot register 0 holds seconds, 1 holds minutes, 2 holds hours and 3 holds day bits 7:0. In register 4, a snapshot keeps bits 7:4, clears bits 3:1 and puts day bit 8 in bit 0.
- R9: Each `tick` advances the running time. Seconds and minutes wrap after 59, hours wrap after 23 and the day count wraps after 511.
- R10: Reset selects ROM bank 1 and RAM bank 0, disables RAM, unmaps the time registers, clears the latched state and zeroes the running time and snapshots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per store |
| tick | input | 1 | One-cycle strobe that advances the running time by one second |
| rom_rdata | input | 8 | Data from the external ROM at `rom_addr` |
| ram_rdata | input | 8 | Data from the external RAM at `ram_addr` |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | $clog2(ROM_BANKS)+14 | Physical ROM byte address |
| ram_addr | output | $clog2(RAM_BANKS)+13 | Physical RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |

## Verification
The bench builds the block with ROM_BANKS = 32 and RAM_BANKS = 4. With 32 banks, requests of 32 and above lie outside the ROM, so the ignored-request path of R3 is reachable with 7-bit data. Bank 31 checks the top of the accepted range. Four RAM banks let the full 0–3 select range show up as distinct `ram_addr` values. The bench writes the time registers through the window to set 23:59:59 on day 511. From there a single tick exercises every wrap at once, which would otherwise take far too many cycles.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;
    localparam int         TREG_NUM  = 5;

    typedef enum logic [2:0] {
        RG_ENABLE = 3'd0,
        RG_ROMSEL = 3'd1,
        RG_RAMSEL = 3'd2,
        RG_LATCH  = 3'd3,
        RG_ROMHI0 = 3'd4,
        RG_WINDOW = 3'd5,
        RG_UPPER0 = 3'd6,
        RG_UPPER1 = 3'd7
    } region_e;

    typedef struct packed {
        logic [6:0] rom_bank;
        logic [1:0] ram_bank;
        logic       ram_en;
        logic       tmap;
        logic [2:0] tsel;
        logic       latched;
    } ctl_t;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [8:0] day;
    } tod_t;

endpackage

// File: rtl/cart_region_decode.sv
module cart_region_decode
    import cart_bank_pkg::*;
(
    input  logic [2:0] addr_top,
    output region_e    region,
    output logic       is_rom,
    output logic       is_window
);
    always_comb begin
        region    = region_e'(addr_top);
        is_rom    = (addr_top[2] == 1'b0);
        is_window = (region == RG_WINDOW);
    end
endmodule

// File: rtl/cart_tod_live.sv
module cart_tod_live
    import cart_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output tod_t       now
);
    tod_t tod_d, tod_q;

    always_comb begin
        tod_d = tod_q;
        if (wr_en) begin
            case (wr_sel)
                3'd0:    tod_d.sec      = wr_data[5:0];
                3'd1:    tod_d.min      = wr_data[5:0];
                3'd2:    tod_d.hour     = wr_data[4:0];
                3'd3:    tod_d.day[7:0] = wr_data;
                3'd4:    tod_d.day[8]   = wr_data[0];
                default: tod_d          = tod_q;
            endcase
        end else if (tick) begin
            if (tod_q.sec >= SEC_LAST) begin
                tod_d.sec = '0;
                if (tod_q.min >= MIN_LAST) begin
                    tod_d.min = '0;
                    if (tod_q.hour >= HOUR_LAST) begin
                        tod_d.hour = '0;
                        tod_d.day  = tod_q.day + 9'd1;
                    end else begin
                        tod_d.hour = tod_q.hour + 5'd1;
                    end
                end else begin
                    tod_d.min = tod_q.min + 6'd1;
                end
            end else begin
                tod_d.sec = tod_q.sec + 6'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tod_q <= '0;
        else        tod_q <= tod_d;
    end

    assign now = tod_q;
endmodule

// File: rtl/cart_tod_snap.sv
module cart_tod_snap
    import cart_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       snap_en,
    input  tod_t       now,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_sel,
    output logic [7:0] rd_data
);
    logic [TREG_NUM-1:0][7:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (snap_en) begin
            regs_d[0] = {2'b00, now.sec};
            regs_d[1] = {2'b00, now.min};
            regs_d[2] = {3'b000, now.hour};
            regs_d[3] = now.day[7:0];
            regs_d[4] = {regs_q[4][7:4], 3'b000, now.day[8]};
        end else if (wr_en) begin
            for (int i = 0; i < TREG_NUM; i++) begin
                if (wr_sel == 3'(i)) regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < TREG_NUM; i++) begin
            if (rd_sel == 3'(i)) rd_data = regs_q[i];
        end
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [15:0]                       cpu_addr,
    input  logic [7:0]                        cpu_wdata,
    input  logic                              cpu_wr,
    input  logic                              tick,
    input  logic [7:0]                        rom_rdata,
    input  logic [7:0]                        ram_rdata,
    output logic [7:0]                        cpu_rdata,
    output logic [$clog2(ROM_BANKS)+13:0]     rom_addr,
    output logic [$clog2(RAM_BANKS)+12:0]     ram_addr,
    output logic [7:0]                        ram_wdata,
    output logic                              ram_we
);
    localparam int         ROM_BW  = $clog2(ROM_BANKS);
    localparam int         RAM_BW  = $clog2(RAM_BANKS);
    localparam logic [7:0] ROM_LIM = 8'(ROM_BANKS);

    region_e    region;
    logic       is_rom;
    logic       is_window;
    ctl_t       ctl_d, ctl_q;
    logic       snap_en;
    logic       twr_en;
    logic [7:0] tod_rdata;
    tod_t       tod_now;
    logic [6:0] rom_req;

    cart_region_decode u_dec (
        .addr_top  (cpu_addr[15:13]),
        .region    (region),
        .is_rom    (is_rom),
        .is_window (is_window)
    );

    always_comb begin
        ctl_d   = ctl_q;
        snap_en = 1'b0;
        rom_req = (cpu_wdata[6:0] == 7'd0) ? 7'd1 : cpu_wdata[6:0];
        if (cpu_wr) begin
            case (region)
                RG_ENABLE: begin
                    if (cpu_wdata == 8'h0A)      ctl_d.ram_en = 1'b1;
                    else if (cpu_wdata == 8'h00) ctl_d.ram_en = 1'b0;
                end
                RG_ROMSEL: begin
                    if ({1'b0, rom_req} < ROM_LIM) ctl_d.rom_bank = rom_req;
                end
                RG_RAMSEL: begin
                    if (cpu_wdata < 8'h04) begin
                        ctl_d.ram_bank = cpu_wdata[1:0];
                        ctl_d.tmap     = 1'b0;
                    end else if (cpu_wdata >= 8'h08 && cpu_wdata <= 8'h0C) begin
                        ctl_d.tsel = 3'(cpu_wdata - 8'h08);
                        ctl_d.tmap = 1'b1;
                    end
                end
                RG_LATCH: begin
                    if (!ctl_q.latched && cpu_wdata == 8'h01) begin
                        ctl_d.latched = 1'b1;
                        snap_en       = 1'b1;
                    end else if (ctl_q.latched && cpu_wdata == 8'h00) begin
                        ctl_d.latched = 1'b0;
                    end
                end
                default: ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.rom_bank <= 7'd1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign twr_en = cpu_wr && is_window && ctl_q.tmap;

    cart_tod_live u_live (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (twr_en),
        .wr_sel  (ctl_q.tsel),
        .wr_data (cpu_wdata),
        .now     (tod_now)
    );

    cart_tod_snap u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap_en (snap_en),
        .now     (tod_now),
        .wr_en   (twr_en),
        .wr_sel  (ctl_q.tsel),
        .wr_data (cpu_wdata),
        .rd_sel  (ctl_q.tsel),
        .rd_data (tod_rdata)
    );

    always_comb begin
        if (cpu_addr[14]) rom_addr = {ctl_q.rom_bank[ROM_BW-1:0], cpu_addr[13:0]};
        else              rom_addr = {{ROM_BW{1'b0}}, cpu_addr[13:0]};
    end

    generate
        if (RAM_BANKS > 1) begin : g_banked_ram
            assign ram_addr = {ctl_q.ram_bank[RAM_BW-1:0], cpu_addr[12:0]};
        end else begin : g_single_ram
            assign ram_addr = cpu_addr[12:0];
        end
    endgenerate

    assign ram_wdata = cpu_wdata;
    assign ram_we    = cpu_wr && is_window && !ctl_q.tmap && ctl_q.ram_en;

    always_comb begin
        if (is_rom)                 cpu_rdata = rom_rdata;
        else if (!is_window)        cpu_rdata = 8'hFF;
        else if (ctl_q.tmap)        cpu_rdata = tod_rdata;
        else if (ctl_q.ram_en)      cpu_rdata = ram_rdata;
        else                        cpu_rdata = 8'hFF;
    end
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr_top,
    input logic [7:0] cpu_wdata,
    input logic       cpu_wr,
    input logic       tick,
    input ctl_t       ctl,
    input tod_t       now
);
    localparam logic [7:0] LIM = 8'(ROM_BANKS);

    logic twr;
    assign twr = cpu_wr && addr_top == 3'd5 && ctl.tmap;

    AST_RAM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && addr_top == 3'd0 && cpu_wdata == 8'h0A |=> ctl.ram_en); // R1
    AST_RAM_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && addr_top == 3'd0 && cpu_wdata == 8'h00 |=> !ctl.ram_en); // R1
    AST_ROM_ZERO_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && addr_top == 3'd1 && cpu_wdata[6:0] == 7'd0 |=> ctl.rom_bank == 7'd1); // R2
    AST_ROM_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && addr_top == 3'd1 && {1'b0, cpu_wdata[6:0]} >= LIM |=> $stable(ctl.rom_bank)); // R3
    AST_RAM_BANK_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && addr_top == 3'd2 && cpu_wdata < 8'h04
        |=> !ctl.tmap && ctl.ram_bank == $past(cpu_wdata[1:0])); // R4
    AST_TREG_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && addr_top == 3'd2 && cpu_wdata >= 8'h08 && cpu_wdata <= 8'h0C
        |=> ctl.tmap && ctl.tsel == $past(cpu_wdata[2:0])); // R4
    AST_LATCH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.latched) |-> $past(cpu_wr && addr_top == 3'd3 && cpu_wdata == 8'h01)); // R7
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !twr && now.sec == 6'd59 |=> now.sec == 6'd0); // R9
    AST_MIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !twr && now.sec == 6'd59 && now.min < 6'd59 |=> now.min == $past(now.min) + 6'd1); // R9
    AST_DAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !twr && now.sec == 6'd59 && now.min == 6'd59 && now.hour == 5'd23
        |=> now.hour == 5'd0 && now.day == $past(now.day) + 9'd1); // R9
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.ROM_BANKS(ROM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_top  (cpu_addr[15:13]),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .tick      (tick),
    .ctl       (ctl_q),
    .now       (tod_now)
);

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ROM_BANKS  = 32;
    localparam int RAM_BANKS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  rom_rdata;
    logic [7:0]  ram_rdata;
    logic [7:0]  cpu_rdata;
    logic [18:0] rom_addr;
    logic [14:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // external memory models: contents are a fixed function of the address
    assign rom_rdata = rom_addr[7:0] ^ 8'hC3;
    assign ram_rdata = ram_addr[7:0] + {ram_addr[14:13], 6'd0};

    cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .tick(tick), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
        .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we)
    );

    function automatic logic [7:0] ram_model(input logic [1:0] bank, input logic [12:0] off);
        return off[7:0] + {bank, 6'd0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1 d = cpu_rdata;
    endtask

    task automatic romaddr(input logic [15:0] a, output logic [18:0] r);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1 r = rom_addr;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic [18:0] r;
        romaddr(16'h4000, r);
        check("R10 rom bank 1 after reset", r, 19'h04000);
        rd(16'hA000, d);
        check("R10 window closed after reset", d, 8'hFF);
        check("R10 ram_we low", ram_we, 1'b0);
        wr(16'h0000, 8'h0A);
        rd(16'hA005, d);
        check("R10 ram bank 0 after reset", d, ram_model(2'd0, 13'h0005));
        wr(16'h4000, 8'h0C);
        rd(16'hA000, d);
        check("R10 snapshot zero after reset", d, 8'h00);
        wr(16'h4000, 8'h00);
        wr(16'h0000, 8'h00);
    endtask

    task automatic t_ram_enable();
        logic [7:0] d;
        wr(16'h1234, 8'h0A);
        rd(16'hA123, d);
        check("R1 enable with 0x0A", d, ram_model(2'd0, 13'h0123));
        wr(16'h1FFF, 8'h05);
        rd(16'hA123, d);
        check("R1 other value keeps enable", d, ram_model(2'd0, 13'h0123));
        wr(16'h0000, 8'h00);
        rd(16'hA123, d);
        check("R1 disable with 0x00", d, 8'hFF);
        wr(16'h0000, 8'h0B);
        rd(16'hA123, d);
        check("R1 other value keeps disable", d, 8'hFF);
    endtask

    task automatic t_rom_bank();
        logic [18:0] r; logic [7:0] d;
        wr(16'h2000, 8'h05);
        romaddr(16'h4ABC, r);
        check("R2 bank 5 address", r, 19'h14ABC);
        rd(16'h4ABC, d);
        check("R2 rom data steered", d, 8'hBC ^ 8'hC3);
        romaddr(16'h1234, r);
        check("R2 fixed bank region", r, 19'h01234);
        wr(16'h3FFF, 8'h00);
        romaddr(16'h7FFF, r);
        check("R2 zero becomes bank 1", r, 19'h07FFF);
        wr(16'h2000, 8'h85);
        romaddr(16'h4000, r);
        check("R2 bit 7 ignored", r, 19'h14000);
    endtask

    task automatic t_rom_range();
        logic [18:0] r;
        wr(16'h2000, 8'h20);
        romaddr(16'h4001, r);
        check("R3 bank 32 ignored", r, 19'h14001);
        wr(16'h2000, 8'h7F);
        romaddr(16'h4001, r);
        check("R3 bank 127 ignored", r, 19'h14001);
        wr(16'h2000, 8'h1F);
        romaddr(16'h4001, r);
        check("R3 bank 31 accepted", r, {5'd31, 14'h0001});
    endtask

    task automatic t_ram_bank();
        logic [7:0] d;
        wr(16'h0000, 8'h0A);
        wr(16'h4000, 8'h02);
        @(negedge clk);
        cpu_addr = 16'hA010; cpu_wdata = 8'h77; cpu_wr = 1'b1;
        #1;
        check("R6 ram_we when enabled", ram_we, 1'b1);
        check("R5 ram_addr bank 2", ram_addr, 15'h4010);
        check("R6 ram_wdata", ram_wdata, 8'h77);
        @(negedge clk);
        cpu_wr = 1'b0;
        wr(16'h5FFF, 8'h07);
        rd(16'hA010, d);
        check("R4 value 7 ignored", d, ram_model(2'd2, 13'h0010));
        wr(16'h4000, 8'h0D);
        rd(16'hBFFF, d);
        check("R4 value 0x0D ignored", d, ram_model(2'd2, 13'h1FFF));
        wr(16'h4000, 8'h03);
        rd(16'hA001, d);
        check("R4 bank 3 selected", d, ram_model(2'd3, 13'h0001));
        rd(16'hC000, d);
        check("R5 above window reads FF", d, 8'hFF);
    endtask

    task automatic t_window_priority();
        logic [7:0] d;
        wr(16'h4000, 8'h08);
        @(negedge clk);
        cpu_addr = 16'hA000; cpu_wdata = 8'h2A; cpu_wr = 1'b1;
        #1 check("R6 no ram_we when mapped", ram_we, 1'b0);
        @(negedge clk);
        cpu_wr = 1'b0;
        rd(16'hA000, d);
        check("R5 mapped register read", d, 8'h2A);
        wr(16'h0000, 8'h00);
        rd(16'hB000, d);
        check("R5 mapped beats disabled ram", d, 8'h2A);
        wr(16'h4000, 8'h01);
        @(negedge clk);
        cpu_addr = 16'hA000; cpu_wdata = 8'h11; cpu_wr = 1'b1;
        #1 check("R6 write dropped when disabled", ram_we, 1'b0);
        @(negedge clk);
        cpu_wr = 1'b0;
        rd(16'hA000, d);
        check("R5 FF when unmapped and disabled", d, 8'hFF);
        wr(16'h0000, 8'h0A);
        rd(16'hA002, d);
        check("R4 unmapped to ram bank 1", d, ram_model(2'd1, 13'h0002));
    endtask

    task automatic set_treg(input logic [7:0] sel, input logic [7:0] v);
        wr(16'h4000, sel);
        wr(16'hA000, v);
    endtask

    task automatic read_treg(input logic [7:0] sel, output logic [7:0] d);
        wr(16'h4000, sel);
        rd(16'hA000, d);
    endtask

    task automatic t_wrap_and_layout();
        logic [7:0] d;
        set_treg(8'h08, 8'd59);
        set_treg(8'h09, 8'd59);
        set_treg(8'h0A, 8'd23);
        set_treg(8'h0B, 8'hFF);
        set_treg(8'h0C, 8'hF1);
        pulse_tick();
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);
        read_treg(8'h08, d); check("R9 seconds wrap", d, 8'd0);
        read_treg(8'h09, d); check("R9 minutes wrap", d, 8'd0);
        read_treg(8'h0A, d); check("R9 hours wrap", d, 8'd0);
        read_treg(8'h0B, d); check("R9 day low wrap", d, 8'd0);
        read_treg(8'h0C, d); check("R8 reg4 keeps nibble, day8 wrap", d, 8'hF0);
        set_treg(8'h08, 8'd58);
        set_treg(8'h09, 8'd10);
        set_treg(8'h0A, 8'd5);
        set_treg(8'h0B, 8'h34);
        set_treg(8'h0C, 8'h5F);
        pulse_tick();
        pulse_tick();
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);
        read_treg(8'h08, d); check("R8 seconds in reg0", d, 8'd0);
        read_treg(8'h09, d); check("R8 minutes in reg1", d, 8'd11);
        read_treg(8'h0A, d); check("R8 hours in reg2", d, 8'd5);
        read_treg(8'h0B, d); check("R8 day low in reg3", d, 8'h34);
        read_treg(8'h0C, d); check("R8 reg4 bits 3:1 cleared", d, 8'h51);
    endtask

    task automatic t_latch_once();
        logic [7:0] d;
        pulse_tick();
        pulse_tick();
        pulse_tick();
        wr(16'h7FFF, 8'h01);
        read_treg(8'h08, d);
        check("R7 repeated 1 does not relatch", d, 8'd0);
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);
        read_treg(8'h08, d);
        check("R7 relatch after 0", d, 8'd3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ram_enable();
        t_rom_bank();
        t_rom_range();
        t_ram_bank();
        t_window_priority();
        t_wrap_and_layout();
        t_latch_once();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule